// File: doc/BRIEF.md
# DMA Control and Interrupt Register Front End

This block is the software-visible register bank of a multi-channel DMA controller. A 32-bit word port, decoded over a 4 KB window, reaches a global configuration word, a sync word and five words per channel: source, destination, link pointer, control and configuration. The transfer engine keeps the data moving elsewhere. This block only holds the settings, latches the engine's terminal-count and error events, and turns them into interrupt lines.

The interrupt masks have no registers of their own. Each channel's configuration word carries a terminal-count enable and an error enable, and these act as the mask bits. Software clears latched events by writing ones. A write to any configuration word sends a one-cycle kick toward the scheduler so that it re-examines the channels. Reads complete one cycle after they are requested. The window also returns a bitmap of enabled channels and eight identification bytes.

Top module: `dma_csr_front`

## Requirements
- R1: After reset every register and every latched event bit is zero, all three interrupt outputs and `kick` are low, and reads return zero.
- R2: Channel n (n below NUM_CH) owns byte addresses 0x100 + n*0x20 + 4*w, where w=0 is source, 1 is destination, 2 is link, 3 is control and 4 is configuration. Each of these words reads back what was last written. Words 5 to 7 of a slot, and slots whose index (address bits 7:5) is NUM_CH or higher, read as zero, and writes to them change nothing.
- R3: The global configuration word at 0x030 and the sync word at 0x034 read back what was last written.
- R4: A high bit on `tcEvt` or `errEvt` sets the matching latched bit, and the latched bits read at 0x014 (terminal count) and 0x018 (error) in bit n for channel n. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R5: Writing to 0x008 clears each latched terminal-count bit whose write-data bit is 1, and writing to 0x010 does the same for the error bits. Bits written as 0 keep their value.
- R6: 0x004 reads the latched terminal-count bits ANDed with bit 15 of each channel's configuration word. 0x00C reads the latched error bits ANDed with bit 14. 0x000 reads the OR of the two.
- R7: `irqTc` is high when any masked terminal-count bit is set, `irqErr` is high when any masked error bit is set, and `irqAny` is their OR.
- R8: 0x01C reads a bitmap whose bit n equals bit 0 of channel n's configuration word.
- R9: The words at 0xFE0 to 0xFFC return one byte each in bits 7:0, with the upper bits zero. In order the bytes are 0x80 when NUM_CH is 8 (0x81 otherwise), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R10: All other offsets read as zero and ignore writes. This covers the software-request words 0x020 to 0x02C, the status words and everything outside the decoded ranges.
- R11: `kick` is high for exactly the one cycle after a write to 0x030 or to any valid channel configuration word. No other write raises it.
- R12: `regRdValid` is high exactly in the cycle after `regRd` was sampled high, and `regRdData` then holds the value selected by the address of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write request this cycle |
| regRd | input | 1 | Read request this cycle |
| regAddr | input | 10 | Word address, byte-address bits 11:2 |
| regWdata | input | 32 | Write data |
| regRdValid | output | 1 | Read data valid |
| regRdData | output | 32 | Read data |
| tcEvt | input | NUM_CH | Terminal-count events from the engine, one per channel |
| errEvt | input | NUM_CH | Error events from the engine, one per channel |
| irqTc | output | 1 | Masked terminal-count interrupt |
| irqErr | output | 1 | Masked error interrupt |
| irqAny | output | 1 | OR of the two interrupts |
| kick | output | 1 | One-cycle pulse after any configuration write |

## Verification
The bench uses the two-channel variant, so slot indices 2 to 7 must decode as absent. A decoder that wrapped the index would alias those writes onto channel 0, and a later read of channel 0 would show the corruption. The clear tests write zero bits, and separately apply an event and a clear to the same bit in one cycle. A design that cleared too much, or let the clear win, would lose a latched event. The masks are switched by rewriting channel configuration words while events are pending, which catches masks read from the wrong bit or the wrong channel. Writes to the status, bitmap and software-request words are followed by readback, and `kick` is checked after every write, so a stray register update or a misfired kick becomes visible.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int CH_WORDS   = 5;
  localparam int CFG_WORD   = 4;
  localparam int TC_EN_BIT  = 15;
  localparam int ERR_EN_BIT = 14;
  localparam int CH_ON_BIT  = 0;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ALL, SEL_TC, SEL_ERR, SEL_RAWTC, SEL_RAWERR,
    SEL_ENBL, SEL_GCFG, SEL_SYNC, SEL_CHAN, SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic       wrGcfg;
    logic       wrSync;
    logic       wrTcClr;
    logic       wrErrClr;
    logic       wrChan;
    logic [2:0] chIdx;
    logic [2:0] chWord;
    logic [2:0] idIdx;
    rdSel_e     rdSel;
  } csrStrb_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx, input logic wide);
    case (idx)
      3'd0:    idByte = wide ? 8'h80 : 8'h81;
      3'd1:    idByte = 8'h10;
      3'd2:    idByte = 8'h04;
      3'd3:    idByte = 8'h0A;
      3'd4:    idByte = 8'h0D;
      3'd5:    idByte = 8'hF0;
      3'd6:    idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWr,
  input  logic [11:2] regAddr,
  output csrStrb_t    strb,
  output logic        kick
);

  localparam logic [3:0] NCH4 = 4'(NUM_CH);

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_ZERO;
    if (regAddr >= 10'h3F8) begin
      strb.rdSel = SEL_ID;
      strb.idIdx = regAddr[4:2];
    end else if (regAddr[11:8] == 4'h1) begin
      if (({1'b0, regAddr[7:5]} < NCH4) && (regAddr[4:2] <= 3'(CFG_WORD))) begin
        strb.rdSel  = SEL_CHAN;
        strb.chIdx  = regAddr[7:5];
        strb.chWord = regAddr[4:2];
        strb.wrChan = regWr;
      end
    end else if (regAddr[11:6] == 6'd0) begin
      case (regAddr[5:2])
        4'd0:  strb.rdSel    = SEL_ALL;
        4'd1:  strb.rdSel    = SEL_TC;
        4'd2:  strb.wrTcClr  = regWr;
        4'd3:  strb.rdSel    = SEL_ERR;
        4'd4:  strb.wrErrClr = regWr;
        4'd5:  strb.rdSel    = SEL_RAWTC;
        4'd6:  strb.rdSel    = SEL_RAWERR;
        4'd7:  strb.rdSel    = SEL_ENBL;
        4'd12: begin strb.rdSel = SEL_GCFG; strb.wrGcfg = regWr; end
        4'd13: begin strb.rdSel = SEL_SYNC; strb.wrSync = regWr; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) kick <= 1'b0;
    else        kick <= strb.wrGcfg | (strb.wrChan && strb.chWord == 3'(CFG_WORD));
  end

  p_kick_gcfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && regAddr == 10'h00C) |=> kick);
  p_kick_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !regWr |=> !kick);

endmodule

// File: rtl/dma_csr_dpath.sv
module dma_csr_dpath
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  csrStrb_t          strb,
  input  logic              regRd,
  input  logic [31:0]       regWdata,
  input  logic [NUM_CH-1:0] tcEvt,
  input  logic [NUM_CH-1:0] errEvt,
  output logic              regRdValid,
  output logic [31:0]       regRdData,
  output logic              irqTc,
  output logic              irqErr,
  output logic              irqAny
);

  localparam logic WIDE = (NUM_CH == 8);

  logic [31:0]       chReg [NUM_CH][CH_WORDS];
  logic [31:0]       gcfg, syncReg, chRd, rdMux;
  logic [NUM_CH-1:0] rawTc, rawErr, tcMask, errMask, chOn, mskTc, mskErr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar w = 0; w < CH_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) chReg[c][w] <= '0;
        else if (strb.wrChan && strb.chIdx == 3'(c) && strb.chWord == 3'(w))
          chReg[c][w] <= regWdata;
      end
    end
    assign tcMask[c]  = chReg[c][CFG_WORD][TC_EN_BIT];
    assign errMask[c] = chReg[c][CFG_WORD][ERR_EN_BIT];
    assign chOn[c]    = chReg[c][CFG_WORD][CH_ON_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcfg    <= '0;
      syncReg <= '0;
      rawTc   <= '0;
      rawErr  <= '0;
    end else begin
      if (strb.wrGcfg) gcfg    <= regWdata;
      if (strb.wrSync) syncReg <= regWdata;
      rawTc  <= (rawTc  & ~(strb.wrTcClr  ? regWdata[NUM_CH-1:0] : '0)) | tcEvt;
      rawErr <= (rawErr & ~(strb.wrErrClr ? regWdata[NUM_CH-1:0] : '0)) | errEvt;
    end
  end

  assign mskTc  = rawTc & tcMask;
  assign mskErr = rawErr & errMask;
  assign irqTc  = |mskTc;
  assign irqErr = |mskErr;
  assign irqAny = irqTc | irqErr;

  always_comb begin
    chRd = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int w = 0; w < CH_WORDS; w++)
        if (strb.chIdx == 3'(c) && strb.chWord == 3'(w)) chRd = chReg[c][w];
  end

  always_comb begin
    case (strb.rdSel)
      SEL_ALL:    rdMux = 32'(mskTc | mskErr);
      SEL_TC:     rdMux = 32'(mskTc);
      SEL_ERR:    rdMux = 32'(mskErr);
      SEL_RAWTC:  rdMux = 32'(rawTc);
      SEL_RAWERR: rdMux = 32'(rawErr);
      SEL_ENBL:   rdMux = 32'(chOn);
      SEL_GCFG:   rdMux = gcfg;
      SEL_SYNC:   rdMux = syncReg;
      SEL_CHAN:   rdMux = chRd;
      SEL_ID:     rdMux = {24'd0, idByte(strb.idIdx, WIDE)};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regRdValid <= 1'b0;
      regRdData  <= '0;
    end else begin
      regRdValid <= regRd;
      if (regRd) regRdData <= rdMux;
    end
  end

  p_tc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tcEvt != '0) |=> ((rawTc & $past(tcEvt)) == $past(tcEvt)));
  p_tc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrTcClr && tcEvt == '0) |=> ((rawTc & $past(regWdata[NUM_CH-1:0])) == '0));
  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrErrClr && errEvt == '0) |=> ((rawErr & $past(regWdata[NUM_CH-1:0])) == '0));
  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    regRd |=> regRdValid);
  p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !regRd |=> !regRdValid);

endmodule

// File: rtl/dma_csr_front.sv
module dma_csr_front
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [11:2]       regAddr,
  input  logic [31:0]       regWdata,
  output logic              regRdValid,
  output logic [31:0]       regRdData,
  input  logic [NUM_CH-1:0] tcEvt,
  input  logic [NUM_CH-1:0] errEvt,
  output logic              irqTc,
  output logic              irqErr,
  output logic              irqAny,
  output logic              kick
);

  csrStrb_t strb;

  dma_csr_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .strb(strb), .kick(kick)
  );

  dma_csr_dpath #(.NUM_CH(NUM_CH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regRd(regRd), .regWdata(regWdata),
    .tcEvt(tcEvt), .errEvt(errEvt), .regRdValid(regRdValid), .regRdData(regRdData),
    .irqTc(irqTc), .irqErr(irqErr), .irqAny(irqAny)
  );

endmodule

// File: tb/sim_dma_csr_front.sv
`timescale 1ns/1ps
module sim_dma_csr_front;
  localparam int NCH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [11:2] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic regRdValid;
  logic [31:0] regRdData;
  logic [NCH-1:0] tcEvt = '0, errEvt = '0;
  logic irqTc, irqErr, irqAny, kick;

  always #5 clk = ~clk;

  dma_csr_front #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdValid(regRdValid), .regRdData(regRdData),
    .tcEvt(tcEvt), .errEvt(errEvt), .irqTc(irqTc), .irqErr(irqErr),
    .irqAny(irqAny), .kick(kick)
  );

  int checks = 0, fails = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic expKick, input string tag);
    @(negedge clk); regWr = 1'b1; regAddr = a[11:2]; regWdata = d;
    @(negedge clk); regWr = 1'b0;
    chk({tag, " R11 kick"}, {31'd0, kick}, {31'd0, expKick});
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regRd = 1'b1; regAddr = a[11:2];
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic irqChk(input logic t, input logic e, input string tag);
    chk({tag, " R7 irqTc"},  {31'd0, irqTc},  {31'd0, t});
    chk({tag, " R7 irqErr"}, {31'd0, irqErr}, {31'd0, e});
    chk({tag, " R7 irqAny"}, {31'd0, irqAny}, {31'd0, t | e});
  endtask

  task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e);
    @(negedge clk); tcEvt = t; errEvt = e;
    @(negedge clk); tcEvt = '0; errEvt = '0;
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  initial forever begin
    @(negedge clk);
    if (regRdValid === 1'b1) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12 unexpected valid actual=%h expected=none", regRdData);
      end else begin
        chk(tagQ.pop_front(), regRdData, expQ.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  logic [7:0] idExp [8];

  initial begin
    idExp = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    irqChk(1'b0, 1'b0, "R1 reset");
    chk("R1 kick reset", {31'd0, kick}, 32'd0);
    rst_n = 1'b1;
    rd(12'h000, 0, "R1 status");
    rd(12'h014, 0, "R1 rawtc");
    rd(12'h030, 0, "R1 gcfg");
    rd(12'h110, 0, "R1 ch0 cfg");

    // R3 global words
    wr(12'h030, 32'h0000_0001, 1'b1, "R3 gcfg");
    wr(12'h034, 32'hA5A5_0003, 1'b0, "R3 sync");
    rd(12'h030, 32'h0000_0001, "R3 gcfg");
    rd(12'h034, 32'hA5A5_0003, "R3 sync");

    // R2 channel words
    wr(12'h100, 32'h1111_0000, 1'b0, "R2 ch0 src");
    wr(12'h104, 32'h2222_0004, 1'b0, "R2 ch0 dst");
    wr(12'h108, 32'h3333_0008, 1'b0, "R2 ch0 lnk");
    wr(12'h10C, 32'h4444_000C, 1'b0, "R2 ch0 ctl");
    wr(12'h130, 32'h0000_C001, 1'b1, "R2 ch1 cfg");
    wr(12'h120, 32'h5555_0020, 1'b0, "R2 ch1 src");
    wr(12'h114, 32'hDEAD_BEEF, 1'b0, "R2 ch0 word5");
    wr(12'h140, 32'h1234_5678, 1'b0, "R2 ch2 absent");
    wr(12'h150, 32'h0000_0001, 1'b0, "R2 ch2 cfg absent");
    rd(12'h100, 32'h1111_0000, "R2 ch0 src");
    rd(12'h104, 32'h2222_0004, "R2 ch0 dst");
    rd(12'h108, 32'h3333_0008, "R2 ch0 lnk");
    rd(12'h10C, 32'h4444_000C, "R2 ch0 ctl");
    rd(12'h130, 32'h0000_C001, "R2 ch1 cfg");
    rd(12'h120, 32'h5555_0020, "R2 ch1 src");
    rd(12'h110, 32'h0, "R2 ch0 cfg untouched");
    rd(12'h114, 32'h0, "R2 word5");
    rd(12'h140, 32'h0, "R2 ch2");
    rd(12'h1F0, 32'h0, "R2 ch7");

    // R8 bitmap
    rd(12'h01C, 32'h2, "R8 enabled map");

    // R4 R6 R7 events and masks
    pulse(2'b11, 2'b01);
    irqChk(1'b1, 1'b0, "R6 tc only");
    rd(12'h014, 32'h3, "R4 raw tc");
    rd(12'h018, 32'h1, "R4 raw err");
    rd(12'h004, 32'h2, "R6 masked tc");
    rd(12'h00C, 32'h0, "R6 masked err");
    rd(12'h000, 32'h2, "R6 combined");
    wr(12'h110, 32'h0000_4000, 1'b1, "R6 ch0 err enable");
    irqChk(1'b1, 1'b1, "R6 both");
    rd(12'h00C, 32'h1, "R6 masked err");
    rd(12'h000, 32'h3, "R6 combined");
    rd(12'h01C, 32'h2, "R8 map after ch0 cfg");

    // R5 write-one-to-clear
    wr(12'h008, 32'h0000_0002, 1'b0, "R5 tc clear");
    rd(12'h014, 32'h1, "R5 raw tc after clear");
    irqChk(1'b0, 1'b1, "R5 tc cleared");
    wr(12'h010, 32'h0, 1'b0, "R5 err zero write");
    rd(12'h018, 32'h1, "R5 err kept");
    wr(12'h010, 32'h1, 1'b0, "R5 err clear");
    rd(12'h018, 32'h0, "R5 err cleared");
    irqChk(1'b0, 1'b0, "R5 all clear");

    // R4 set beats clear
    @(negedge clk); regWr = 1'b1; regAddr = 12'h008 >> 2; regWdata = 32'h3; tcEvt = 2'b01;
    @(negedge clk); regWr = 1'b0; tcEvt = '0;
    rd(12'h014, 32'h1, "R4 set wins");

    // R10 unmapped and read-only words
    wr(12'h020, 32'hFFFF_FFFF, 1'b0, "R10 swreq");
    wr(12'h014, 32'h0, 1'b0, "R10 raw write");
    wr(12'h01C, 32'hFF, 1'b0, "R10 map write");
    wr(12'h038, 32'hFFFF_FFFF, 1'b0, "R10 gap write");
    wr(12'h800, 32'hFFFF_FFFF, 1'b0, "R10 far write");
    rd(12'h020, 0, "R10 swreq0");
    rd(12'h02C, 0, "R10 swreq3");
    rd(12'h038, 0, "R10 gap");
    rd(12'h200, 0, "R10 0x200");
    rd(12'h800, 0, "R10 0x800");
    rd(12'h014, 32'h1, "R10 raw untouched");
    rd(12'h01C, 32'h2, "R10 map untouched");
    rd(12'h034, 32'hA5A5_0003, "R10 sync untouched");
    rd(12'h030, 32'h1, "R10 gcfg untouched");

    // R9 identification
    for (int i = 0; i < 8; i++)
      rd(12'hFE0 + 12'(4 * i), {24'd0, idExp[i]}, "R9 id byte");

    repeat (4) @(negedge clk);
    chk("R12 queue drained", 32'(expQ.size()), 32'd0);
    chk("R12 idle valid", {31'd0, regRdValid}, 32'd0);
    finish_run();
  end

endmodule